// File: doc/BRIEF.md
# Factory bad-block scanner

This block runs once after power-up, or whenever it is told to start again, and builds a one-bit-per-block table of the erase blocks that arrive from the factory marked bad in a small-page NAND array. It does not drive the flash pins itself. It asks a page-read engine for single words through a request stream that carries a page address and a column. It takes the answer from a response strobe that has no back-pressure. The page address is `block * PAGES + page`.

Block 0 is guaranteed good. It is recorded as good without being read. Every other block is probed on its first two pages at the spare-area marker column or columns. Any marker that does not hold the erased value makes the block bad. Once a block is known to be bad, its remaining probes are skipped.

When the scan finishes, the block raises a done flag. It also reports how many bad blocks it found, and flags an anomaly when that number goes above the expected factory limit. A lookup port returns the stored bit for any block with one cycle of latency.

Request stream rules: `rd_req_valid` rises only when no read is outstanding. Once it is high, it stays high with row and column unchanged until `rd_req_ready` is seen high at a clock edge. The only exception is a `start` pulse, which may replace the pending request. After each accepted request, the block waits for exactly one `rd_rsp_valid` strobe before it issues another.

Top module: `bad_block_scan`

## Requirements
- R1: After reset, `done` is 0, `bad_count` is 0, `anomaly` is 0, `rd_req_valid` is 0, and every lookup returns 0.
- R2: A `start` pulse clears the table, the count and the anomaly flag, so that `bad_count` reads 0 on the next cycle. The scan then covers blocks 1 to NB-1 in ascending order. Block 0 is never requested and always reads back as good.
- R3: Requests carry row = block*PAGES + page (page 0 or 1). A request is held stable until it is accepted. At most one read is outstanding, and the next request follows only after the response strobe.
- R4: In 8-bit mode (WIDE16=0), each block is probed at column 517, first on page 0 and then on page 1. The block is bad if a returned byte is not FFh.
- R5: In 16-bit mode (WIDE16=1), each block is probed in this order: page 0 column 256, page 0 column 261, page 1 column 256, page 1 column 261. The block is bad if any returned word is not FFFFh.
- R6: After the first non-erased marker of a block, that block gets no further reads. A good block receives all of its probes (2 in 8-bit mode, 4 in 16-bit mode).
- R7: `lk_bad` shows the table bit of the block presented on `lk_block` at the previous clock edge (1 = bad).
- R8: `done` rises after the decision on the last block. It stays high, with no requests issued, until the next `start`.
- R9: `bad_count` equals the number of blocks recorded bad. `anomaly` is high exactly when `bad_count` is above MAX_BAD (20).
- R10: A `start` during a scan abandons that scan. The block waits for any outstanding response, discards it, and then rescans from block 1 with cleared results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: clear results and begin a scan |
| rd_req_valid | output | 1 | Read request present |
| rd_req_ready | input | 1 | Read engine accepts the request |
| rd_req_row | output | log2(NB)+log2(PAGES) | Page address of the read |
| rd_req_col | output | COL_W | Column of the read |
| rd_rsp_valid | input | 1 | One-cycle strobe carrying the read result |
| rd_rsp_data | input | 8 or 16 | Returned byte or word |
| lk_block | input | log2(NB) | Block index to look up |
| lk_bad | output | 1 | Table bit of the looked-up block, one cycle later |
| done | output | 1 | Scan complete |
| bad_count | output | log2(NB)+1 | Number of blocks recorded bad |
| anomaly | output | 1 | Bad count exceeds MAX_BAD |

## Verification
The bench places the bad marker on each probe slot in turn, including the last slot of the last block. A design that stopped early would miss the block, and one that kept reading after a hit would show extra reads per block. Marker values differ from the erased value only in the lowest bit, so a comparison that looks at part of the word lets a bad block through. Ready stalls and response latency are varied, and a reference model flags any request that changes while waiting, any second request issued before the response, or any out-of-order probe. `start` is pulsed at several offsets into a running scan, so a stale in-flight response would be credited to block 1 unless it is flushed. The anomaly flag is checked at counts of exactly 20 and 21.

// File: rtl/bbs_pkg.sv
`timescale 1ns/1ps
package bbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FLUSH,
    ST_DONE
  } scan_state_e;
endpackage

// File: rtl/bbs_probe_map.sv
`timescale 1ns/1ps
// Turns (block, probe index) into the page address and column of one marker read.
module bbs_probe_map #(
  parameter bit WIDE16     = 1'b1,
  parameter int BLK_W      = 11,
  parameter int PG_W       = 5,
  parameter int PRB_W      = 2,
  parameter int COL_W      = 10,
  parameter int COL_BYTE   = 517,
  parameter int COL_WORD_A = 256,
  parameter int COL_WORD_B = 261
) (
  input  logic [BLK_W-1:0]      blk,
  input  logic [PRB_W-1:0]      probe,
  output logic [BLK_W+PG_W-1:0] row,
  output logic [COL_W-1:0]      col,
  output logic                  last
);
  logic pg_sel;

  generate
    if (WIDE16) begin : g_word
      // two columns per page, page changes on the upper probe bit
      always_comb begin
        pg_sel = probe[PRB_W-1];
        col    = probe[0] ? COL_W'(COL_WORD_B) : COL_W'(COL_WORD_A);
        last   = &probe;
      end
    end else begin : g_byte
      always_comb begin
        pg_sel = probe[0];
        col    = COL_W'(COL_BYTE);
        last   = probe[0];
      end
    end
  endgenerate

  assign row = {blk, {(PG_W-1){1'b0}}, pg_sel};
endmodule

// File: rtl/bbs_bitmap.sv
`timescale 1ns/1ps
// One bit per block, registered lookup.
module bbs_bitmap #(
  parameter int NB    = 2048,
  parameter int BLK_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_idx,
  input  logic [BLK_W-1:0] lk_idx,
  output logic             lk_bad
);
  logic [NB-1:0] map_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      map_q <= '0;
    else if (clr)    map_q <= '0;
    else if (set_en) map_q[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lk_bad <= 1'b0;
    else        lk_bad <= map_q[lk_idx];
  end

  AST_BLOCK0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !map_q[0]); // R2
  AST_MARK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((map_q & $past(map_q)) == $past(map_q))); // R2
  AST_ONE_MARK_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($countones(map_q ^ $past(map_q)) <= 1)); // R6
endmodule

// File: rtl/bbs_tally.sv
`timescale 1ns/1ps
// Saturating bad-block counter with limit flag.
module bbs_tally #(
  parameter int CNT_W   = 12,
  parameter int MAX_BAD = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             anomaly
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (inc && !(&count))   count <= count + 1'b1;
  end

  assign anomaly = (count > LIMIT);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count)) || (count == $past(count) + 1'b1)); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R2
endmodule

// File: rtl/bad_block_scan.sv
`timescale 1ns/1ps
module bad_block_scan
  import bbs_pkg::*;
#(
  parameter bit WIDE16     = 1'b1,
  parameter int NB         = 2048,
  parameter int PAGES      = 32,
  parameter int MAX_BAD    = 20,
  parameter int COL_W      = 10,
  parameter int COL_BYTE   = 517,
  parameter int COL_WORD_A = 256,
  parameter int COL_WORD_B = 261,
  localparam int DW        = WIDE16 ? 16 : 8,
  localparam int BLK_W     = $clog2(NB),
  localparam int PG_W      = $clog2(PAGES),
  localparam int ROW_W     = BLK_W + PG_W,
  localparam int CNT_W     = BLK_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [ROW_W-1:0] rd_req_row,
  output logic [COL_W-1:0] rd_req_col,
  input  logic             rd_rsp_valid,
  input  logic [DW-1:0]    rd_rsp_data,
  input  logic [BLK_W-1:0] lk_block,
  output logic             lk_bad,
  output logic             done,
  output logic [CNT_W-1:0] bad_count,
  output logic             anomaly
);
  localparam int                PRB_W    = WIDE16 ? 2 : 1;
  localparam logic [DW-1:0]     ERASED   = {DW{1'b1}};
  localparam logic [BLK_W-1:0]  LAST_BLK = BLK_W'(NB - 1);
  localparam logic [BLK_W-1:0]  FIRST    = BLK_W'(1);

  scan_state_e       state_q;
  logic [BLK_W-1:0]  blk_q;
  logic [PRB_W-1:0]  probe_q;
  logic              probe_last;
  logic              rsp_take, marked, mark_bad, block_end, in_flight;

  bbs_probe_map #(
    .WIDE16(WIDE16), .BLK_W(BLK_W), .PG_W(PG_W), .PRB_W(PRB_W), .COL_W(COL_W),
    .COL_BYTE(COL_BYTE), .COL_WORD_A(COL_WORD_A), .COL_WORD_B(COL_WORD_B)
  ) u_map (
    .blk(blk_q), .probe(probe_q), .row(rd_req_row), .col(rd_req_col), .last(probe_last)
  );

  assign rsp_take  = (state_q == ST_WAIT) && rd_rsp_valid;
  assign marked    = (rd_rsp_data != ERASED);
  assign mark_bad  = rsp_take && marked && !start;
  assign block_end = rsp_take && (marked || probe_last);
  // a read is still owed to us after this edge: must be drained on restart
  assign in_flight = ((state_q == ST_ISSUE) && rd_req_ready) ||
                     (((state_q == ST_WAIT) || (state_q == ST_FLUSH)) && !rd_rsp_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      blk_q   <= FIRST;
      probe_q <= '0;
    end else if (start) begin
      blk_q   <= FIRST;
      probe_q <= '0;
      state_q <= in_flight ? ST_FLUSH : ST_ISSUE;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: ;
        ST_ISSUE: if (rd_req_ready) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            if (block_end) begin
              probe_q <= '0;
              if (blk_q == LAST_BLK) begin
                state_q <= ST_DONE;
              end else begin
                blk_q   <= blk_q + 1'b1;
                state_q <= ST_ISSUE;
              end
            end else begin
              probe_q <= probe_q + PRB_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_FLUSH: if (rd_rsp_valid) state_q <= ST_ISSUE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state_q == ST_ISSUE);
  assign done         = (state_q == ST_DONE);

  bbs_bitmap #(.NB(NB), .BLK_W(BLK_W)) u_bitmap (
    .clk(clk), .rst_n(rst_n), .clr(start), .set_en(mark_bad), .set_idx(blk_q),
    .lk_idx(lk_block), .lk_bad(lk_bad)
  );

  bbs_tally #(.CNT_W(CNT_W), .MAX_BAD(MAX_BAD)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(mark_bad),
    .count(bad_count), .anomaly(anomaly)
  );

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready && !start |=>
      rd_req_valid && $stable(rd_req_row) && $stable(rd_req_col)); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid); // R3
  AST_NO_BLOCK0_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_row[ROW_W-1:PG_W] != '0)); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req_valid); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R8
endmodule

// File: tb/bad_block_scan_test.sv
`timescale 1ns/1ps
// Read-engine model: accepts requests, answers after a latency, logs reads per block.
module bbs_nand_model #(
  parameter int DW     = 16,
  parameter int PPB    = 32,
  parameter int NB     = 64,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int MODE16 = 1
) (
  input  logic             clk,
  input  logic             restart,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data
);
  // written by the bench only
  int bad_loc [NB];
  int stall;
  int lat;
  int clr_gen;
  // written by this model only
  int reads [NB];
  int errs;
  int total;

  initial begin
    int seen_gen, pend, last_blk, last_slot, cyc;
    logic prev_wait;
    logic [ROW_W-1:0] prev_row;
    logic [COL_W-1:0] prev_col;
    logic [DW-1:0] pend_data;
    seen_gen = 0; pend = -1; last_blk = 0; last_slot = 0; cyc = 0;
    prev_wait = 1'b0; prev_row = '0; prev_col = '0; pend_data = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    errs = 0; total = 0;
    foreach (reads[i]) reads[i] = 0;
    forever begin
      @(negedge clk); #1;
      cyc++;
      if (seen_gen != clr_gen) begin
        seen_gen = clr_gen;
        foreach (reads[i]) reads[i] = 0;
        errs = 0; total = 0; last_blk = 0; last_slot = 0;
      end
      if (prev_wait && !(req_valid && req_row == prev_row && req_col == prev_col)) errs++;
      rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rsp_valid = 1'b1; rsp_data = pend_data; pend = -1;
        end
      end
      req_ready = (stall != 0) ? ((cyc % 3) != 0) : 1'b1;
      if (req_valid && req_ready) begin
        int blk, pg, slot;
        if (pend >= 0) errs++;
        blk = int'(req_row) / PPB;
        pg  = int'(req_row) % PPB;
        slot = 0;
        if (pg <= 1) begin
          if (MODE16 != 0) begin
            if (int'(req_col) == 256) slot = pg * 2 + 1;
            else if (int'(req_col) == 261) slot = pg * 2 + 2;
          end else if (int'(req_col) == 517) begin
            slot = pg + 1;
          end
        end
        if (slot == 0) errs++;
        if (!((blk == last_blk && slot == last_slot + 1) || (blk == last_blk + 1 && slot == 1))) errs++;
        last_blk = blk; last_slot = slot;
        reads[blk]++; total++;
        pend_data = (slot != 0 && slot == bad_loc[blk]) ? ({DW{1'b1}} ^ DW'(1)) : {DW{1'b1}};
        pend = lat;
      end
      prev_wait = req_valid && !req_ready && !restart;
      prev_row = req_row; prev_col = req_col;
    end
  end
endmodule

module bad_block_scan_test;
  localparam int NB = 64, PPB = 32, BLK_W = 6, ROW_W = 11, COL_W = 10, CNT_W = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic start16, start8;
  logic v16, r16, rv16, lkb16, done16, an16;
  logic v8, r8, rv8, lkb8, done8, an8;
  logic [ROW_W-1:0] row16, row8;
  logic [COL_W-1:0] col16, col8;
  logic [15:0] d16;
  logic [7:0] d8;
  logic [BLK_W-1:0] lk16, lk8;
  logic [CNT_W-1:0] cnt16, cnt8;

  int checks = 0, fails = 0;
  bit finished = 0;

  bad_block_scan #(.WIDE16(1'b1), .NB(NB), .PAGES(PPB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start16), .rd_req_valid(v16), .rd_req_ready(r16),
    .rd_req_row(row16), .rd_req_col(col16), .rd_rsp_valid(rv16), .rd_rsp_data(d16),
    .lk_block(lk16), .lk_bad(lkb16), .done(done16), .bad_count(cnt16), .anomaly(an16));

  bad_block_scan #(.WIDE16(1'b0), .NB(NB), .PAGES(PPB)) uut_b8 (
    .clk(clk), .rst_n(rst_n), .start(start8), .rd_req_valid(v8), .rd_req_ready(r8),
    .rd_req_row(row8), .rd_req_col(col8), .rd_rsp_valid(rv8), .rd_rsp_data(d8),
    .lk_block(lk8), .lk_bad(lkb8), .done(done8), .bad_count(cnt8), .anomaly(an8));

  bbs_nand_model #(.DW(16), .PPB(PPB), .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .MODE16(1)) m16 (
    .clk(clk), .restart(start16), .req_valid(v16), .req_ready(r16), .req_row(row16),
    .req_col(col16), .rsp_valid(rv16), .rsp_data(d16));

  bbs_nand_model #(.DW(8), .PPB(PPB), .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .MODE16(0)) m8 (
    .clk(clk), .restart(start8), .req_valid(v8), .req_ready(r8), .req_row(row8),
    .req_col(col8), .rsp_valid(rv8), .rsp_data(d8));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_table(input bit w16, input int blk, input int slot);
    if (w16) m16.bad_loc[blk] = slot; else m8.bad_loc[blk] = slot;
  endtask

  task automatic clear_tables();
    for (int i = 0; i < NB; i++) begin m16.bad_loc[i] = 0; m8.bad_loc[i] = 0; end
  endtask

  task automatic go(input bit w16);
    if (w16) start16 = 1'b1; else start8 = 1'b1;
    @(negedge clk);
    start16 = 1'b0; start8 = 1'b0;
    if (w16) m16.clr_gen++; else m8.clr_gen++;
  endtask

  task automatic wait_done(input bit w16);
    int n = 0;
    while (!(w16 ? done16 : done8) && n < 20000) begin @(negedge clk); n++; end
    check(w16 ? done16 : done8, "R8 scan reaches done", 0, 1);
  endtask

  // Compare everything observable after a finished scan with the bench table.
  task automatic check_result(input bit w16, input int exp_cnt, input string tag);
    int cnt, bad_rd, bad_lk, loc, full;
    full = w16 ? 4 : 2;
    cnt = w16 ? int'(cnt16) : int'(cnt8);
    check(cnt == exp_cnt, {"R9 bad count ", tag}, cnt, exp_cnt);
    check((w16 ? an16 : an8) == (exp_cnt > 20), {"R9 anomaly ", tag},
          int'(w16 ? an16 : an8), int'(exp_cnt > 20));
    check((w16 ? m16.errs : m8.errs) == 0, {"R3 request protocol/order ", tag},
          w16 ? m16.errs : m8.errs, 0);
    check((w16 ? m16.reads[0] : m8.reads[0]) == 0, {"R2 block 0 never read ", tag},
          w16 ? m16.reads[0] : m8.reads[0], 0);
    bad_rd = 0;
    for (int i = 1; i < NB; i++) begin
      loc = w16 ? m16.bad_loc[i] : m8.bad_loc[i];
      if ((w16 ? m16.reads[i] : m8.reads[i]) != (loc == 0 ? full : loc)) bad_rd++;
    end
    check(bad_rd == 0, w16 ? {"R5 R6 reads per block ", tag} : {"R4 R6 reads per block ", tag}, bad_rd, 0);
    bad_lk = 0;
    for (int i = 0; i < NB; i++) begin
      if (w16) lk16 = BLK_W'(i); else lk8 = BLK_W'(i);
      @(negedge clk);
      loc = w16 ? m16.bad_loc[i] : m8.bad_loc[i];
      if ((w16 ? lkb16 : lkb8) != (loc != 0)) bad_lk++;
    end
    check(bad_lk == 0, {"R7 lookup table contents ", tag}, bad_lk, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start16 = 1'b0; start8 = 1'b0; lk16 = 6'd9; lk8 = 6'd9;
    m16.stall = 0; m16.lat = 1; m16.clr_gen = 0;
    m8.stall = 0; m8.lat = 1; m8.clr_gen = 0;
    clear_tables();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done16 && !done8, "R1 done low after reset", int'(done16), 0);
    check(cnt16 == 0 && cnt8 == 0, "R1 count zero after reset", int'(cnt16), 0);
    check(!an16 && !an8, "R1 anomaly low after reset", int'(an16), 0);
    check(!v16 && !v8, "R1 no request after reset", int'(v16), 0);
    check(!lkb16 && !lkb8, "R1 lookup zero after reset", int'(lkb16), 0);
  endtask

  task automatic t_clean16();
    int tot;
    clear_tables(); m16.stall = 0; m16.lat = 1;
    go(1); wait_done(1);
    check_result(1, 0, "clean 16-bit");
    tot = m16.total;
    repeat (10) @(negedge clk);
    check(done16, "R8 done held", int'(done16), 1);
    check(m16.total == tot && !v16, "R8 no reads while done", m16.total, tot);
  endtask

  task automatic t_marks16();
    clear_tables(); m16.stall = 1; m16.lat = 3;
    set_table(1, 1, 1); set_table(1, 7, 2); set_table(1, 20, 3);
    set_table(1, 33, 4); set_table(1, 63, 4);
    go(1); wait_done(1);
    check_result(1, 5, "marks on every slot R5 R6");
  endtask

  task automatic t_lookup16();
    lk16 = 6'd6;
    @(negedge clk);
    lk16 = 6'd7;
    #1;
    check(lkb16 == 1'b0, "R7 lookup not yet updated", int'(lkb16), 0);
    @(negedge clk);
    check(lkb16 == 1'b1, "R7 lookup after one edge", int'(lkb16), 1);
  endtask

  task automatic t_limit16();
    clear_tables(); m16.stall = 0; m16.lat = 2;
    for (int i = 2; i <= 22; i++) set_table(1, i, (i % 4) + 1);
    go(1); wait_done(1);
    check_result(1, 21, "21 bad");
    set_table(1, 22, 0);
    lk16 = 6'd5;
    go(1);
    check(cnt16 == 0, "R2 start clears count", int'(cnt16), 0);
    check(!an16, "R2 start clears anomaly", int'(an16), 0);
    @(negedge clk);
    check(!lkb16, "R2 start clears table", int'(lkb16), 0);
    wait_done(1);
    check_result(1, 20, "20 bad boundary");
  endtask

  task automatic t_restart16();
    clear_tables(); m16.stall = 1; m16.lat = 2;
    set_table(1, 4, 2); set_table(1, 2, 1);
    for (int k = 0; k < 6; k++) begin
      go(1);
      repeat (30 + k) @(negedge clk);
    end
    clear_tables();
    set_table(1, 10, 3); set_table(1, 40, 1);
    go(1); wait_done(1);
    check_result(1, 2, "R10 restart mid-scan");
  endtask

  task automatic t_mode8();
    clear_tables(); m8.stall = 1; m8.lat = 1;
    set_table(0, 3, 1); set_table(0, 9, 2); set_table(0, 63, 2);
    go(0); wait_done(0);
    check_result(0, 3, "8-bit mode R4");
  endtask

  initial begin
    t_reset();
    t_clean16();
    t_marks16();
    t_lookup16();
    t_limit16();
    t_restart16();
    t_mode8();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #750000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R8 watchdog expired: actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule